// File: doc/BRIEF.md
# GPIO Port with Interrupt Logic

This block is a parameterized general-purpose I/O port that sits on a simple memory-mapped register bus. Software reads the pin levels, drives output data and output enables, and selects per-bit interrupt behaviour. The block then raises a single combined interrupt line when any enabled bit has a pending event. By default the port is 16 bits wide.

Each control register has two addresses, one that sets bits and one that clears them. Software can therefore change one bit without a read-modify-write sequence. Output data can also be written through two windows, one per byte lane. In these windows the low address bits act as a write mask, so only the selected output bits take the new value.

The pins pass through a synchronizer. The synchronized sample feeds the data-in register and also a level and edge detector for each bit. Each detector sets a sticky status bit. Pad drivers, pin routing and bus bridging are outside this block.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, all of these read zero: output data, output enable, interrupt enable, interrupt type, interrupt polarity and status. `pad_oe` and `irq` are low.
- R2: The control registers use these address pairs, each given as set address then clear address, with region bits 00: output enable 2 and 3, interrupt enable 4 and 5, interrupt type 6 and 7, polarity 8 and 9. On the set address, a 1 in the write data sets that bit. On the clear address, a 1 clears that bit. A 0 leaves the bit unchanged. Reading either address returns the current value.
- R3: Address 1 in region 00 holds the full output-data register, which drives `pad_out`. Reads return the value last written.
- R4: A write to region 01 (addr[9:8]=01) changes only the output bits [7:0] selected by addr[7:0]. Those bits take wdata[7:0]. Output bits [15:8] are unchanged.
- R5: A write to region 10 changes only the output bits [15:8] selected by the mask addr[7:0]. Those bits take wdata[15:8]. Output bits [7:0] are unchanged.
- R6: Address 0 of region 00 returns the synchronized pin level. This holds whatever the output enable is. A pin change driven before clock edge k is visible in the read after edge k+1, and is not yet visible after edge k.
- R7: With type 0 (level), a bit's status sets while its synchronized pin equals its polarity bit (1 means high, 0 means low). While that level persists, the status bit sets again after a clear.
- R8: With type 1 (edge), a bit's status sets on a rising edge when the polarity bit is 1, and on a falling edge when it is 0. The opposite edge sets nothing. The status bit stays set until it is cleared.
- R9: Address 10 of region 00 reads the pending status. Writing 1 to a bit clears it. Writing 0 has no effect.
- R10: If a clear-status write and a new qualifying edge on the same bit occur in the same cycle, the status bit ends up set.
- R11: A status bit can become set only while its interrupt enable is set. `irq` is the OR of all status bits whose enable is set. Clearing an enable masks that bit from `irq` but does not clear its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid when `bus_sel` is high |
| bus_addr | input | 10 | Word address: bits [9:8] region, bits [3:0] register offset, bits [7:0] byte-lane mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Output data to the pads |
| pad_oe | output | 16 | Output enables to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted control register appears on `pad_oe` in the cycle after the write. It also appears in the very next read of its set address. A detector fault, such as a wrong polarity, a wrong edge/level choice or a lost edge, shows up as a wrong bit in the status read two to three cycles after the pin moves. It shows on `irq` at the same time. A status bit that clears when it should not, or that survives a clear under a persisting level, shows on the status read after the clear write. Lane-mask errors show on `pad_out` in the cycle after a window write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // address regions, decoded from the two top address bits
   localparam logic [1:0] RGN_CTRL = 2'd0;
   localparam logic [1:0] RGN_LOW  = 2'd1;
   localparam logic [1:0] RGN_HIGH = 2'd2;

   // register offsets inside the control region
   localparam logic [3:0] OFS_DIN      = 4'd0;
   localparam logic [3:0] OFS_DOUT     = 4'd1;
   localparam logic [3:0] OFS_CTL_BASE = 4'd2;
   localparam logic [3:0] OFS_STAT     = 4'd10;

   // set/clear register pairs: index k uses offsets BASE+2k (set) and BASE+2k+1 (clear)
   localparam int CTL_REGS = 4;
   localparam int CTL_OE   = 0;
   localparam int CTL_IE   = 1;
   localparam int CTL_TYPE = 2;
   localparam int CTL_POL  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int DATA_W = 16,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [DATA_W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10,
   localparam int LANE_W = DATA_W / 2,
   localparam int CTL_W  = CTL_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] stat,
   output logic [DATA_W-1:0] dout_q,
   output logic [CTL_W-1:0]  ctl_flat,
   output logic [DATA_W-1:0] stat_clr
);
   logic              wr_en;
   logic [1:0]        region;
   logic [3:0]        ofs;
   logic [LANE_W-1:0] lmask;
   logic [3:0]        rel;

   assign wr_en  = bus_sel & bus_wr;
   assign region = bus_addr[ADDR_W-1 -: 2];
   assign ofs    = bus_addr[3:0];
   assign lmask  = bus_addr[LANE_W-1:0];
   assign rel    = ofs - OFS_CTL_BASE;

   // set/clear register pairs
   for (genvar k = 0; k < CTL_REGS; k++) begin : g_ctl
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && region == RGN_CTRL) begin
            if (ofs == OFS_CTL_BASE + 4'(2*k))
               q <= q | bus_wdata;
            else if (ofs == OFS_CTL_BASE + 4'(2*k + 1))
               q <= q & ~bus_wdata;
         end
      end
      assign ctl_flat[k*DATA_W +: DATA_W] = q;
   end

   // output data: full write or lane-masked windows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
      end else if (wr_en) begin
         case (region)
            RGN_CTRL: if (ofs == OFS_DOUT) dout_q <= bus_wdata;
            RGN_LOW:  dout_q[LANE_W-1:0] <= (dout_q[LANE_W-1:0] & ~lmask)
                                          | (bus_wdata[LANE_W-1:0] & lmask);
            RGN_HIGH: dout_q[DATA_W-1:LANE_W] <= (dout_q[DATA_W-1:LANE_W] & ~lmask)
                                               | (bus_wdata[DATA_W-1:LANE_W] & lmask);
            default: ;
         endcase
      end
   end

   assign stat_clr = (wr_en && region == RGN_CTRL && ofs == OFS_STAT) ? bus_wdata : '0;

   always_comb begin
      bus_rdata = '0;
      case (region)
         RGN_CTRL: begin
            if (ofs == OFS_DIN)       bus_rdata = din;
            else if (ofs == OFS_DOUT) bus_rdata = dout_q;
            else if (ofs == OFS_STAT) bus_rdata = stat;
            else if (ofs >= OFS_CTL_BASE && ofs < OFS_CTL_BASE + 4'(2*CTL_REGS))
               bus_rdata = ctl_flat[32'(rel[3:1]) * DATA_W +: DATA_W];
         end
         RGN_LOW, RGN_HIGH: bus_rdata = dout_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] smp,
   input  logic [DATA_W-1:0] ie,
   input  logic [DATA_W-1:0] itype,
   input  logic [DATA_W-1:0] ipol,
   input  logic [DATA_W-1:0] clr,
   output logic [DATA_W-1:0] stat_q
);
   logic [DATA_W-1:0] prev_q;
   logic [DATA_W-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic rise, fall, edge_hit, level_hit;
      assign rise      = smp[i] & ~prev_q[i];
      assign fall      = ~smp[i] & prev_q[i];
      assign edge_hit  = ipol[i] ? rise : fall;
      assign level_hit = ~(smp[i] ^ ipol[i]);
      assign hit[i]    = ie[i] & (itype[i] ? edge_hit : level_hit);
   end

   // a new event in the clear cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr) | hit;
   end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
   import gpio_port_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_in,
   output logic [DATA_W-1:0] pad_out,
   output logic [DATA_W-1:0] pad_oe,
   output logic              irq
);
   localparam int LANE_W = DATA_W / 2;
   localparam int CTL_W  = CTL_REGS * DATA_W;

   if (DATA_W % 2 != 0 || DATA_W < 8 || DATA_W > 32) begin : g_bad_width
      $error("gpio_port_irq: DATA_W must be even and within 8..32");
   end
   if (ADDR_W < LANE_W + 2 || ADDR_W < 6) begin : g_bad_addr
      $error("gpio_port_irq: ADDR_W too small for the lane mask and region bits");
   end

   logic [DATA_W-1:0] sync_q;
   logic [DATA_W-1:0] dout_q;
   logic [CTL_W-1:0]  ctl_flat;
   logic [DATA_W-1:0] stat_clr;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] oe_q, ie_q, type_q, pol_q;

   gpio_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
   );

   gpio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .din(sync_q), .stat(stat_q),
      .dout_q(dout_q), .ctl_flat(ctl_flat), .stat_clr(stat_clr)
   );

   assign oe_q   = ctl_flat[CTL_OE*DATA_W   +: DATA_W];
   assign ie_q   = ctl_flat[CTL_IE*DATA_W   +: DATA_W];
   assign type_q = ctl_flat[CTL_TYPE*DATA_W +: DATA_W];
   assign pol_q  = ctl_flat[CTL_POL*DATA_W  +: DATA_W];

   gpio_irq_detect #(.DATA_W(DATA_W)) u_det (
      .clk(clk), .rst_n(rst_n), .smp(sync_q),
      .ie(ie_q), .itype(type_q), .ipol(pol_q),
      .clr(stat_clr), .stat_q(stat_q)
   );

   assign pad_out = dout_q;
   assign pad_oe  = oe_q;
   assign irq     = |(stat_q & ie_q);
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
   import gpio_port_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] pad_out,
   input logic [DATA_W-1:0] pad_oe,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] ie_q
);
   localparam int LANE_W = DATA_W / 2;

   logic              wr_ctrl;
   logic              oe_set_wr, oe_clr_wr, low_wr, high_wr;
   logic [DATA_W-1:0] clr_mask;

   assign wr_ctrl   = bus_sel & bus_wr & (bus_addr[ADDR_W-1 -: 2] == RGN_CTRL);
   assign oe_set_wr = wr_ctrl & (bus_addr[3:0] == OFS_CTL_BASE);
   assign oe_clr_wr = wr_ctrl & (bus_addr[3:0] == OFS_CTL_BASE + 4'd1);
   assign low_wr    = bus_sel & bus_wr & (bus_addr[ADDR_W-1 -: 2] == RGN_LOW);
   assign high_wr   = bus_sel & bus_wr & (bus_addr[ADDR_W-1 -: 2] == RGN_HIGH);
   assign clr_mask  = (wr_ctrl && bus_addr[3:0] == OFS_STAT) ? bus_wdata : '0;

   AST_OE_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_set_wr |=> pad_oe == ($past(pad_oe) | $past(bus_wdata)));  // R2
   AST_OE_CLR_ONLY_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      oe_clr_wr |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata))); // R2
   AST_LOW_WINDOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      low_wr |=> $stable(pad_out[DATA_W-1:LANE_W]));                // R4
   AST_HIGH_WINDOW_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      high_wr |=> $stable(pad_out[LANE_W-1:0]));                    // R5
   AST_STAT_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat_q) & ~stat_q & ~$past(clr_mask)) == '0);          // R9
   AST_STAT_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~$past(stat_q) & ~$past(ie_q)) == '0);              // R11
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
   .pad_oe(pad_oe), .stat_q(stat_q), .ie_q(ie_q)
);

// File: tb/gpio_port_irq_tb.sv
`timescale 1ns/1ps
module gpio_port_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pad_out, pad_oe;
   logic        irq;

   int vectors = 0;
   int errs = 0;
   bit done = 0;

   // reference model
   logic [15:0] m_dout = '0, m_oe = '0, m_ie = '0, m_ty = '0, m_pol = '0, m_stat = '0, m_pin = '0;

   always #10 clk = ~clk;

   gpio_port_irq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   function automatic logic exp_irq();
      return |(m_stat & m_ie);
   endfunction

   function automatic void model_level();
      m_stat |= m_ie & ~m_ty & ~(m_pin ^ m_pol);
   endfunction

   function automatic void model_write(logic [9:0] a, logic [15:0] d);
      logic [7:0] m;
      m = a[7:0];
      case (a[9:8])
         2'd0: case (a[3:0])
            4'd1:  m_dout = d;
            4'd2:  m_oe  |= d;
            4'd3:  m_oe  &= ~d;
            4'd4:  m_ie  |= d;
            4'd5:  m_ie  &= ~d;
            4'd6:  m_ty  |= d;
            4'd7:  m_ty  &= ~d;
            4'd8:  m_pol |= d;
            4'd9:  m_pol &= ~d;
            4'd10: m_stat &= ~d;
            default: ;
         endcase
         2'd1: m_dout[7:0]  = (m_dout[7:0] & ~m) | (d[7:0] & m);
         2'd2: m_dout[15:8] = (m_dout[15:8] & ~m) | (d[15:8] & m);
         default: ;
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
      vectors++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [9:0] a, logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
      model_write(a, d);
   endtask

   task automatic rd(logic [9:0] a, output logic [15:0] v);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      bus_sel = 1'b0; bus_addr = '0;
   endtask

   task automatic set_pins(logic [15:0] v);
      logic [15:0] rise, fall;
      @(negedge clk);
      rise = v & ~m_pin;
      fall = ~v & m_pin;
      m_stat |= m_ie & m_ty & ((m_pol & rise) | (~m_pol & fall));
      pin_in = v;
      m_pin = v;
      idle(4);
      model_level();
   endtask

   task automatic settle();
      idle(2);
      model_level();
   endtask

   task automatic check_all();
      logic [15:0] v;
      @(negedge clk);
      rd(10'd0, v);  chk("R6 din", v, m_pin);
      rd(10'd1, v);  chk("R3 dout", v, m_dout);
      rd(10'd2, v);  chk("R2 oe", v, m_oe);
      rd(10'd5, v);  chk("R2 ie", v, m_ie);
      rd(10'd6, v);  chk("R2 type", v, m_ty);
      rd(10'd9, v);  chk("R2 pol", v, m_pol);
      rd(10'd10, v); chk("R9 stat", v, m_stat);
      chk("R3 pad_out", pad_out, m_dout);
      chk("R2 pad_oe", pad_oe, m_oe);
      chk("R11 irq", {15'd0, irq}, {15'd0, exp_irq()});
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL R1 watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int unsigned r;
      r = $urandom(32'h5eed_1234);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check_all();
      chk("R1 irq_reset", {15'd0, irq}, 16'd0);

      // R6 synchronizer timing and input path with output enabled
      wr(10'd2, 16'hFFFF);
      @(negedge clk);
      pin_in = 16'hA5A5;
      @(negedge clk);
      rd(10'd0, v); chk("R6 din_not_yet", v, 16'h0000);
      @(negedge clk);
      rd(10'd0, v); chk("R6 din_after_two_edges", v, 16'hA5A5);
      m_pin = 16'hA5A5;
      set_pins(16'h0000);
      wr(10'd3, 16'hFFFF);
      check_all();

      // R4 / R5 lane windows
      wr(10'd1, 16'hFFFF);
      wr({2'b01, 8'h0F}, 16'h0000);
      chk("R4 low_window", pad_out, 16'hFFF0);
      wr({2'b10, 8'h80}, 16'h0000);
      chk("R5 high_window", pad_out, 16'h7FF0);
      wr({2'b10, 8'h01}, 16'h5A5A);
      chk("R5 high_window_mask_bit8", pad_out, 16'h7EF0);

      // R7 level: bit0 high-active, bit1 low-active
      wr(10'd8, 16'h0001);
      wr(10'd4, 16'h0003);
      settle();
      rd(10'd10, v); chk("R7 low_level_sets", v & 16'h0003, 16'h0002);
      set_pins(16'h0001);
      rd(10'd10, v); chk("R7 high_level_sets", v & 16'h0001, 16'h0001);
      wr(10'd10, 16'h0001);
      settle();
      rd(10'd10, v); chk("R7 level_persists_after_clear", v & 16'h0001, 16'h0001);
      set_pins(16'h0002);
      wr(10'd10, 16'h0003);
      settle();
      rd(10'd10, v); chk("R7 cleared_when_inactive", v & 16'h0003, 16'h0000);
      chk("R11 irq_idle", {15'd0, irq}, 16'd0);
      wr(10'd5, 16'h0003);
      set_pins(16'h0000);
      check_all();

      // R8 edge: bit4 rising, bit5 falling
      wr(10'd6, 16'h0030);
      wr(10'd8, 16'h0010);
      wr(10'd9, 16'h0020);
      wr(10'd4, 16'h0030);
      settle();
      rd(10'd10, v); chk("R8 no_event_idle", v & 16'h0030, 16'h0000);
      set_pins(16'h0030);
      rd(10'd10, v); chk("R8 rise_sets_only_rising", v & 16'h0030, 16'h0010);
      set_pins(16'h0000);
      rd(10'd10, v); chk("R8 fall_sets_falling", v & 16'h0030, 16'h0030);
      idle(5);
      rd(10'd10, v); chk("R8 sticky", v & 16'h0030, 16'h0030);
      wr(10'd10, 16'h0000);
      settle();
      rd(10'd10, v); chk("R9 write_zero_no_effect", v & 16'h0030, 16'h0030);
      wr(10'd10, 16'h0010);
      settle();
      rd(10'd10, v); chk("R8 clear_edge", v & 16'h0030, 16'h0020);

      // R11 masking without clearing
      wr(10'd5, 16'h0020);
      settle();
      chk("R11 irq_masked", {15'd0, irq}, 16'd0);
      rd(10'd10, v); chk("R11 stat_kept", v & 16'h0020, 16'h0020);
      wr(10'd4, 16'h0020);
      settle();
      chk("R11 irq_unmasked", {15'd0, irq}, 16'd1);

      // R10 clear and new rising edge on bit4 in the same cycle
      set_pins(16'h0010);
      set_pins(16'h0000);
      @(negedge clk);
      pin_in = 16'h0010;
      m_pin = 16'h0010;
      @(negedge clk);
      wr(10'd10, 16'h0010);
      m_stat |= 16'h0010;
      settle();
      rd(10'd10, v); chk("R10 edge_wins", v & 16'h0010, 16'h0010);
      check_all();

      // constrained random
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: set_pins(16'($urandom));
            1: begin
               wr(10'($urandom_range(2, 9)), 16'($urandom));
               settle();
            end
            2: begin wr(10'd1, 16'($urandom)); settle(); end
            3: begin wr({2'b01, 8'($urandom)}, 16'($urandom)); settle(); end
            4: begin wr({2'b10, 8'($urandom)}, 16'($urandom)); settle(); end
            default: begin wr(10'd10, 16'($urandom)); settle(); end
         endcase
         check_all();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end
endmodule